// File: doc/BRIEF.md
# VLAN Membership Table Command Engine

This block keeps a small VLAN membership table for a multi-port Ethernet switch. Software changes the table only through two registers. It writes a data word first and a command word second. The command word names an operation and sets an active bit. The engine then performs the operation over one or more clocks and clears the active bit when it finishes. While the active bit is set, writes to either register are dropped. A combinational lookup port maps a 12-bit VLAN ID to a port member mask and a hit flag, and the switch datapath uses it to look up frames.

Control is a three-state machine:
- IDLE waits for an accepted command.
- EXEC performs the single-cycle operations: load, purge and no-op.
- WALK steps through the table one entry per clock for flush and remove-port.

The transitions are:
- IDLE→EXEC on an accepted load, purge, no-op or unused opcode.
- IDLE→WALK on an accepted flush or remove-port.
- EXEC→IDLE always, one clock later.
- WALK→IDLE once the last entry has been handled.

Each table entry stores a VID, a member mask, a priority, a priority-enable bit and a valid bit.

Top module: `vlan_cmd_engine`

## Requirements
- R1: After reset, `cmd_rd` and `data_rd` read 0 and every lookup misses (`lk_hit`=0, `lk_mask`=0).
- R2: Command word layout:
  - bits [2:0] opcode: 0 no-op, 1 flush, 2 load, 3 purge, 4 remove-port, 5 to 7 behave as no-op.
  - bit 3 active.
  - bit 4 full, read-only.
  - bits [11:8] port.
  - bits [27:16] VID.
  - bits [30:28] priority.
  - bit 31 priority enable.
  A command write with bit 3 clear is ignored. An accepted command reads back with its fields and bit 3 set.
- R3: A load takes the member mask (data bits [9:0]) and the valid bit (data bit 11) from the data register, and the VID from the command register. When no valid entry holds that VID, the load fills the lowest-indexed free slot. Active stays high for exactly one clock after the accepting edge.
- R4: A load whose VID matches a valid entry overwrites that entry, so no two valid entries share a VID.
- R5: A load of a new VID when all entries are valid sets full (bit 4) and leaves the table unchanged. The next accepted command clears full.
- R6: Purge invalidates only the entry whose VID matches. A purge with no match changes nothing.
- R7: Flush invalidates every entry. Active stays high for exactly ENTRIES clocks.
- R8: Remove-port clears the named port's bit in every entry's mask. It also keeps active high for ENTRIES clocks. A port number of 10 or more changes nothing.
- R9: While active is set, command writes and data writes are ignored.
- R10: The lookup is combinational and shows the result of a completed command right after the edge that clears active.
- R11: Opcode 0 and opcodes 5 to 7 leave the table unchanged and complete one clock after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the command register, 1 selects the data register |
| wr_data | input | 32 | Register write data |
| cmd_rd | output | 32 | Command register contents, including active and full |
| data_rd | output | 32 | Data register contents |
| lk_vid | input | 12 | VLAN ID to look up |
| lk_hit | output | 1 | A valid entry matches `lk_vid` |
| lk_mask | output | 10 | Member mask of the matching entry, 0 on a miss |

## Verification
The full flag is the hardest state to reach: it needs all sixteen slots valid with distinct VIDs before one more distinct load arrives. The stimulus flushes the table, loads sixteen consecutive VIDs, and then loads a seventeenth. It then confirms three things: the new VID misses, the old VIDs still hit, and a load that matches an existing VID both succeeds and clears full. The ignored-while-busy rule is reached by writing a new command and new data in the clocks right after a flush is accepted, while the walk is still running.

// File: rtl/vlan_pkg.sv
package vlan_pkg;
    localparam int VID_W  = 12;
    localparam int MASK_W = 10;
    localparam int PRIO_W = 3;

    localparam logic [2:0] OP_NOP    = 3'd0;
    localparam logic [2:0] OP_FLUSH  = 3'd1;
    localparam logic [2:0] OP_LOAD   = 3'd2;
    localparam logic [2:0] OP_PURGE  = 3'd3;
    localparam logic [2:0] OP_RMPORT = 3'd4;

    typedef struct packed {
        logic              valid;
        logic              pen;
        logic [PRIO_W-1:0] prio;
        logic [MASK_W-1:0] mask;
        logic [VID_W-1:0]  vid;
    } vent_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_EXEC = 2'd1,
        S_WALK = 2'd2
    } vst_e;
endpackage

// File: rtl/vlan_tbl.sv
module vlan_tbl
    import vlan_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  vent_t             wentry,
    input  logic [IDX_W-1:0]  ridx,
    output vent_t             rentry,
    input  logic [VID_W-1:0]  q_vid,
    output logic              q_hit,
    output logic [IDX_W-1:0]  q_idx,
    output logic              free_ok,
    output logic [IDX_W-1:0]  free_idx,
    input  logic [VID_W-1:0]  lk_vid,
    output logic              lk_hit,
    output logic [MASK_W-1:0] lk_mask
);
    vent_t tbl_q [ENTRIES];
    logic [ENTRIES-1:0] lk_match;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= '0;
        end else if (we) begin
            tbl_q[widx] <= wentry;
        end
    end

    assign rentry = tbl_q[ridx];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_match
        assign lk_match[g] = tbl_q[g].valid && (tbl_q[g].vid == lk_vid);
    end

    // Scan from high to low so the lowest index wins.
    always_comb begin
        q_hit    = 1'b0;
        q_idx    = '0;
        free_ok  = 1'b0;
        free_idx = '0;
        lk_hit   = 1'b0;
        lk_mask  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (tbl_q[i].valid && tbl_q[i].vid == q_vid) begin
                q_hit = 1'b1;
                q_idx = IDX_W'(i);
            end
            if (!tbl_q[i].valid) begin
                free_ok  = 1'b1;
                free_idx = IDX_W'(i);
            end
            if (lk_match[i]) begin
                lk_hit  = 1'b1;
                lk_mask = tbl_q[i].mask;
            end
        end
    end

    AST_UNIQUE_VID: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lk_match) <= 1); // R4
endmodule

// File: rtl/vlan_fsm.sv
module vlan_fsm
    import vlan_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [31:0]       wr_data,
    output logic [31:0]       cmd_rd,
    output logic [31:0]       data_rd,
    output logic              tbl_we,
    output logic [IDX_W-1:0]  tbl_widx,
    output vent_t             tbl_wentry,
    output logic [IDX_W-1:0]  tbl_ridx,
    input  vent_t             tbl_rentry,
    output logic [VID_W-1:0]  q_vid,
    input  logic              q_hit,
    input  logic [IDX_W-1:0]  q_idx,
    input  logic              free_ok,
    input  logic [IDX_W-1:0]  free_idx
);
    vst_e              state_q, state_d;
    logic [2:0]        op_q;
    logic [3:0]        port_q;
    logic [VID_W-1:0]  vid_q;
    logic [PRIO_W-1:0] prio_q;
    logic              pen_q, active_q, full_q, dvalid_q;
    logic [MASK_W-1:0] dmask_q;
    logic [IDX_W-1:0]  widx_q;
    logic              accept, dwrite, walk_op, walk_last;
    logic              unused_wr;

    assign unused_wr = ^{wr_data[7:4], wr_data[15:12], wr_data[31:12], wr_data[10]};
    assign accept    = wr_en && !wr_sel && wr_data[3] && !active_q;
    assign dwrite    = wr_en && wr_sel && !active_q;
    assign walk_op   = (op_q == OP_FLUSH) || (op_q == OP_RMPORT);
    assign walk_last = (widx_q == IDX_W'(ENTRIES - 1));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (accept)
                        state_d = (wr_data[2:0] == OP_FLUSH || wr_data[2:0] == OP_RMPORT)
                                  ? S_WALK : S_EXEC;
            S_EXEC: state_d = S_IDLE;
            S_WALK: if (walk_last) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= '0; port_q <= '0; vid_q <= '0; prio_q <= '0; pen_q <= 1'b0;
            active_q <= 1'b0; full_q <= 1'b0; dvalid_q <= 1'b0; dmask_q <= '0;
            widx_q <= '0;
        end else begin
            if (accept) begin
                op_q     <= wr_data[2:0];
                port_q   <= wr_data[11:8];
                vid_q    <= wr_data[27:16];
                prio_q   <= wr_data[30:28];
                pen_q    <= wr_data[31];
                active_q <= 1'b1;
                full_q   <= 1'b0;
                widx_q   <= '0;
            end
            if (dwrite) begin
                dmask_q  <= wr_data[MASK_W-1:0];
                dvalid_q <= wr_data[11];
            end
            if (state_q == S_EXEC) begin
                active_q <= 1'b0;
                full_q   <= (op_q == OP_LOAD) && !q_hit && !free_ok;
            end
            if (state_q == S_WALK) begin
                widx_q <= widx_q + IDX_W'(1);
                if (walk_last) active_q <= 1'b0;
            end
        end
    end

    // Outputs
    always_comb begin
        q_vid      = vid_q;
        tbl_ridx   = (state_q == S_WALK) ? widx_q : q_idx;
        tbl_we     = 1'b0;
        tbl_widx   = tbl_ridx;
        tbl_wentry = tbl_rentry;
        unique case (state_q)
            S_EXEC: begin
                if (op_q == OP_LOAD && (q_hit || free_ok)) begin
                    tbl_we     = 1'b1;
                    tbl_widx   = q_hit ? q_idx : free_idx;
                    tbl_wentry = '{valid: dvalid_q, pen: pen_q, prio: prio_q,
                                   mask: dmask_q, vid: vid_q};
                end else if (op_q == OP_PURGE && q_hit) begin
                    tbl_we           = 1'b1;
                    tbl_wentry.valid = 1'b0;
                end
            end
            S_WALK: begin
                tbl_we = 1'b1;
                if (op_q == OP_FLUSH) tbl_wentry.valid = 1'b0;
                else tbl_wentry.mask = tbl_rentry.mask & ~(MASK_W'(1) << port_q);
            end
            default: ;
        endcase
    end

    assign cmd_rd  = {pen_q, prio_q, vid_q, 4'b0, port_q, 3'b0, full_q, active_q, op_q};
    assign data_rd = {20'b0, dvalid_q, 1'b0, dmask_q};

    // Busy-length checker
    logic [IDX_W:0] busy_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)        busy_cnt <= '0;
        else if (accept)   busy_cnt <= '0;
        else if (active_q) busy_cnt <= busy_cnt + 1'b1;
    end

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && wr_en && !wr_sel) |=> ($stable(vid_q) && $stable(op_q))); // R9
    AST_SHORT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EXEC) |=> !active_q); // R3
    AST_WALK_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(active_q) && walk_op) |-> (busy_cnt == (IDX_W+1)'(ENTRIES))); // R7
    AST_FULL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EXEC && op_q == OP_LOAD && !q_hit && !free_ok) |-> !tbl_we); // R5
endmodule

// File: rtl/vlan_cmd_engine.sv
module vlan_cmd_engine
    import vlan_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [31:0] wr_data,
    output logic [31:0] cmd_rd,
    output logic [31:0] data_rd,
    input  logic [11:0] lk_vid,
    output logic        lk_hit,
    output logic [9:0]  lk_mask
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic              tbl_we, q_hit, free_ok;
    logic [IDX_W-1:0]  tbl_widx, tbl_ridx, q_idx, free_idx;
    vent_t             tbl_wentry, tbl_rentry;
    logic [VID_W-1:0]  q_vid;

    vlan_fsm #(.ENTRIES(ENTRIES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cmd_rd(cmd_rd), .data_rd(data_rd), .tbl_we(tbl_we), .tbl_widx(tbl_widx),
        .tbl_wentry(tbl_wentry), .tbl_ridx(tbl_ridx), .tbl_rentry(tbl_rentry),
        .q_vid(q_vid), .q_hit(q_hit), .q_idx(q_idx), .free_ok(free_ok),
        .free_idx(free_idx)
    );

    vlan_tbl #(.ENTRIES(ENTRIES)) u_tbl (
        .clk(clk), .rst_n(rst_n), .we(tbl_we), .widx(tbl_widx), .wentry(tbl_wentry),
        .ridx(tbl_ridx), .rentry(tbl_rentry), .q_vid(q_vid), .q_hit(q_hit),
        .q_idx(q_idx), .free_ok(free_ok), .free_idx(free_idx), .lk_vid(lk_vid),
        .lk_hit(lk_hit), .lk_mask(lk_mask)
    );
endmodule

// File: tb/vlan_cmd_engine_bench.sv
module vlan_cmd_engine_bench;
    localparam int CLK_P = 10;
    localparam int NENT  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] cmd_rd, data_rd;
    logic [11:0] lk_vid = '0;
    logic        lk_hit;
    logic [9:0]  lk_mask;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [11:0] vid;
        logic        hit;
        logic [9:0]  mask;
        string       req;
    } exp_t;
    exp_t sb[$];

    vlan_cmd_engine #(.ENTRIES(NENT)) u_vlan_cmd_engine (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cmd_rd(cmd_rd), .data_rd(data_rd), .lk_vid(lk_vid), .lk_hit(lk_hit),
        .lk_mask(lk_mask)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [31:0] mk_cmd(input logic [2:0] op, input logic [3:0] port,
                                           input logic [11:0] vid);
        return {1'b0, 3'd0, vid, 4'b0, port, 3'b0, 1'b0, 1'b1, op};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: compares lookup outputs against queued expectations.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (lk_vid !== e.vid || lk_hit !== e.hit || lk_mask !== e.mask) begin
                    errors++;
                    $display("FAIL %s: vid %0d actual hit=%b mask=%h expected hit=%b mask=%h",
                             e.req, lk_vid, lk_hit, lk_mask, e.hit, e.mask);
                end
            end
        end
    end

    task automatic look(input logic [11:0] vid, input logic hit, input logic [9:0] mask,
                        input string req);
        exp_t e;
        @(negedge clk);
        lk_vid = vid;
        e.vid = vid; e.hit = hit; e.mask = mask; e.req = req;
        sb.push_back(e);
    endtask

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
    endtask

    task automatic wr_reg(input logic sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (cmd_rd[3]) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic run_cmd(input logic [2:0] op, input logic [3:0] port,
                           input logic [11:0] vid, output int n);
        drain();
        wr_reg(1'b0, mk_cmd(op, port, vid));
        wait_idle(n);
    endtask

    task automatic load(input logic [11:0] vid, input logic [9:0] mask, output int n);
        drain();
        wr_reg(1'b1, {20'b0, 1'b1, 1'b0, mask});
        run_cmd(3'd2, 4'd0, vid, n);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 cmd_rd", cmd_rd, 32'h0);
        check("R1 data_rd", data_rd, 32'h0);
        look(12'd0, 1'b0, 10'h0, "R1 lookup vid0");
        look(12'd5, 1'b0, 10'h0, "R1 lookup vid5");
        drain();

        // R2 command write with active bit clear is ignored
        wr_reg(1'b0, mk_cmd(3'd2, 4'd0, 12'd7) & ~32'h8);
        check("R2 no start", cmd_rd, 32'h0);

        // R3 load into free slot, single-cycle busy
        load(12'd100, 10'h003, n);
        check("R3 load cycles", n, 1);
        check("R2 readback", cmd_rd, 32'h0064_0002);
        look(12'd100, 1'b1, 10'h003, "R3/R10 load hit");

        // R4 overwrite matching VID
        load(12'd100, 10'h30C, n);
        look(12'd100, 1'b1, 10'h30C, "R4 overwrite");
        load(12'd200, 10'h001, n);
        look(12'd200, 1'b1, 10'h001, "R3 second load");

        // R6 purge
        run_cmd(3'd3, 4'd0, 12'd999, n);
        look(12'd100, 1'b1, 10'h30C, "R6 nomatch keeps 100");
        look(12'd200, 1'b1, 10'h001, "R6 nomatch keeps 200");
        run_cmd(3'd3, 4'd0, 12'd100, n);
        look(12'd100, 1'b0, 10'h000, "R6 purge 100");
        look(12'd200, 1'b1, 10'h001, "R6 keeps 200");

        // R8 remove-port
        load(12'd300, 10'h3FF, n);
        run_cmd(3'd4, 4'd0, 12'd0, n);
        check("R8 walk cycles", n, NENT);
        look(12'd300, 1'b1, 10'h3FE, "R8 port0 off 300");
        look(12'd200, 1'b1, 10'h000, "R8 port0 off 200");
        run_cmd(3'd4, 4'd12, 12'd0, n);
        look(12'd300, 1'b1, 10'h3FE, "R8 port12 no effect");

        // R9 writes during a walk are ignored
        drain();
        wr_reg(1'b0, mk_cmd(3'd1, 4'd0, 12'd0));
        wr_reg(1'b1, 32'h0000_0805);
        wr_reg(1'b0, mk_cmd(3'd2, 4'd0, 12'd77));
        wait_idle(n);
        check("R9 op kept", cmd_rd[2:0], 32'd1);
        check("R9 vid kept", cmd_rd[27:16], 32'd0);
        check("R9 data kept", data_rd, 32'h0000_0BFF);
        look(12'd77, 1'b0, 10'h0, "R9 load dropped");
        look(12'd300, 1'b0, 10'h0, "R7 flushed 300");

        // R7 flush length
        run_cmd(3'd1, 4'd0, 12'd0, n);
        check("R7 flush cycles", n, NENT);

        // R5 full table
        for (int i = 0; i < NENT; i++) load(12'(1000 + i), 10'(i + 1), n);
        check("R5 not full yet", cmd_rd[4], 32'd0);
        load(12'd1016, 10'h155, n);
        check("R5 full set", cmd_rd[4], 32'd1);
        look(12'd1016, 1'b0, 10'h0, "R5 no insert");
        look(12'd1000, 1'b1, 10'h001, "R5 keeps first");
        look(12'd1015, 1'b1, 10'h010, "R5 keeps last");
        load(12'd1005, 10'h02A, n);
        check("R5 full cleared", cmd_rd[4], 32'd0);
        look(12'd1005, 1'b1, 10'h02A, "R5/R4 overwrite when full");

        // R11 no-op and unused opcodes
        run_cmd(3'd0, 4'd0, 12'd1000, n);
        check("R11 nop cycles", n, 1);
        run_cmd(3'd6, 4'd3, 12'd1000, n);
        check("R11 op6 cycles", n, 1);
        look(12'd1000, 1'b1, 10'h001, "R11 table unchanged");
        drain();
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule